// File: doc/BRIEF.md
# Low-Frequency Output Divider Synchroniser

This block takes the enable stream of a loop's high-rate output clock and divides it down into two low-rate square waves: a frame-rate clock (nominally 8 kHz) and a multiframe-rate clock at one quarter of that rate (nominally 2 kHz). Both waves come from counters advanced by the high-rate enable. Neither is derived from the reference input, so they keep the loop's filtering even when the loop follows a reference at a much higher frequency.

To give the low-rate outputs a defined phase, the counters can be cleared from an external multiframe reference. The reference input is synchronised into the clock domain and its rising edge is detected. When resynchronisation is enabled and the loop reports lock, that edge clears both counters together. After this, both outputs have their rising edges on the reference edge. A flag reports that this has happened. Once aligned, a reference edge that lands on the counters' natural wrap point, or one high-rate tick to either side of it, leaves the counters running. This avoids a glitch or a stretched cycle at the outputs.

Top module: `lowfreq_divsync`

## Requirements
- R1: During reset and directly after it, `clk8kOut` and `clk2kOut` are 1 and `alignDoneOut` is 0. The divider position is 0.
- R2: The divider position counts high-rate ticks modulo `TICKS_PER_FAST*SLOW_DIV`. `clk8kOut` is 1 exactly when (position mod `TICKS_PER_FAST`) is less than `TICKS_PER_FAST/2`.
- R3: `clk2kOut` is 1 exactly when the position is less than `TICKS_PER_FAST*SLOW_DIV/2`. Its rising edge always coincides with a rising edge of `clk8kOut`.
- R4: The position advances by one on each clock edge where `tickEnIn` is 1. With `tickEnIn` at 0 it holds, and both outputs hold.
- R5: A 0-to-1 change of `syncRefIn` made between clock edges clears the position to 0 at the third following rising clock edge. The clear wins over a tick in that same cycle.
- R6: A reference edge clears nothing unless `syncEnIn` and `lockedIn` are both 1 at the clearing edge.
- R7: `alignDoneOut` becomes 1 at the edge where a clear takes place. It becomes 0 at any edge where `lockedIn` is 0, and clearing it has priority.
- R8: While `alignDoneOut` is 1, a reference edge that finds the position at its last value or at 0 does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEnIn | input | 1 | One pulse per high-rate output cycle of the loop |
| syncRefIn | input | 1 | Asynchronous multiframe reference |
| lockedIn | input | 1 | Loop lock status |
| syncEnIn | input | 1 | Enables resynchronisation |
| clk8kOut | output | 1 | Frame-rate clock |
| clk2kOut | output | 1 | Multiframe-rate clock |
| alignDoneOut | output | 1 | Outputs aligned to the reference |

## Verification
The reference edge is swept across every divider position under three tick patterns: enable always high, enable every other cycle, and a pseudo-random enable. The always-high pattern shows whether the clear lands on the exact edge. The gapped patterns show whether a clear is told apart from a natural wrap, and whether a clear takes priority over a simultaneous tick. Further sequences toggle the reference with lock or enable low, then drop lock after alignment. These separate the gating of the clear from the flag's clear path, and show that window suppression stops once the flag has dropped.

// File: rtl/lowfreq_divsync_pkg.sv
package lowfreq_divsync_pkg;
  // strobes issued by the control to the datapath
  typedef struct packed {
    logic clearDiv;
  } ctrlStrobe_t;

  // status returned by the datapath to the control
  typedef struct packed {
    logic nearBoundary;
  } dpStatus_t;
endpackage

// File: rtl/lowfreq_divsync_ctrl.sv
module lowfreq_divsync_ctrl
  import lowfreq_divsync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncRefIn,
  input  logic        lockedIn,
  input  logic        syncEnIn,
  input  dpStatus_t   dpStatus,
  output ctrlStrobe_t strobe,
  output logic        alignDone
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncPrev;
  logic                   refRise;
  logic                   suppress;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '0;
      syncPrev  <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], syncRefIn};
      syncPrev  <= syncChain[SYNC_STAGES-1];
    end
  end

  assign refRise  = syncChain[SYNC_STAGES-1] & ~syncPrev;
  assign suppress = alignDone & dpStatus.nearBoundary;

  always_comb begin
    strobe          = '0;
    strobe.clearDiv = refRise & syncEnIn & lockedIn & ~suppress;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                alignDone <= 1'b0;
    else if (!lockedIn)       alignDone <= 1'b0;
    else if (strobe.clearDiv) alignDone <= 1'b1;
  end

  // R7: losing lock always drops the flag
  p_flag_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    !lockedIn |=> !alignDone);
  // R7: the flag only rises after a clear
  p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alignDone) |-> $past(strobe.clearDiv));
endmodule

// File: rtl/lowfreq_divsync_datapath.sv
module lowfreq_divsync_datapath
  import lowfreq_divsync_pkg::*;
#(
  parameter int TICKS_PER_FAST = 9720,
  parameter int SLOW_DIV       = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   dpStatus,
  output logic        fastOut,
  output logic        slowOut
);
  localparam int FW = (TICKS_PER_FAST > 1) ? $clog2(TICKS_PER_FAST) : 1;
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [FW-1:0] FAST_LAST = FW'(TICKS_PER_FAST - 1);
  localparam logic [FW-1:0] FAST_HALF = FW'(TICKS_PER_FAST / 2);
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);
  localparam logic [SW-1:0] SLOW_HALF = SW'(SLOW_DIV / 2);

  logic [FW-1:0] fastCnt, fastNext;
  logic [SW-1:0] slowCnt, slowNext;

  always_comb begin
    fastNext = fastCnt;
    slowNext = slowCnt;
    if (strobe.clearDiv) begin
      fastNext = '0;
      slowNext = '0;
    end else if (tickEn) begin
      if (fastCnt == FAST_LAST) begin
        fastNext = '0;
        slowNext = (slowCnt == SLOW_LAST) ? '0 : slowCnt + 1'b1;
      end else begin
        fastNext = fastCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastCnt <= '0;
      slowCnt <= '0;
      fastOut <= 1'b1;
      slowOut <= 1'b1;
    end else begin
      fastCnt <= fastNext;
      slowCnt <= slowNext;
      fastOut <= (fastNext < FAST_HALF);
      slowOut <= (slowNext < SLOW_HALF);
    end
  end

  always_comb begin
    dpStatus = '0;
    dpStatus.nearBoundary = ((slowCnt == SLOW_LAST) && (fastCnt == FAST_LAST)) ||
                            ((slowCnt == '0) && (fastCnt == '0));
  end

  // R2: fast counter never leaves its range
  p_fast_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    fastCnt <= FAST_LAST);
  // R4: no tick and no clear means nothing moves
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strobe.clearDiv) |=> ($stable(fastCnt) && $stable(slowCnt) && $stable(fastOut)));
  // R5: a clear lands both counters on zero
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearDiv |=> (fastCnt == '0 && slowCnt == '0));
  // R3: slow rising edge coincides with a fast high phase start
  p_slow_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slowOut) |-> (fastOut && fastCnt == '0));
endmodule

// File: rtl/lowfreq_divsync.sv
module lowfreq_divsync
  import lowfreq_divsync_pkg::*;
#(
  parameter int TICKS_PER_FAST = 9720,
  parameter int SLOW_DIV       = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEnIn,
  input  logic syncRefIn,
  input  logic lockedIn,
  input  logic syncEnIn,
  output logic clk8kOut,
  output logic clk2kOut,
  output logic alignDoneOut
);
  ctrlStrobe_t strobe;
  dpStatus_t   dpStatus;

  lowfreq_divsync_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk(clk),
    .rstN(rstN),
    .syncRefIn(syncRefIn),
    .lockedIn(lockedIn),
    .syncEnIn(syncEnIn),
    .dpStatus(dpStatus),
    .strobe(strobe),
    .alignDone(alignDoneOut)
  );

  lowfreq_divsync_datapath #(
    .TICKS_PER_FAST(TICKS_PER_FAST),
    .SLOW_DIV(SLOW_DIV)
  ) i_datapath (
    .clk(clk),
    .rstN(rstN),
    .tickEn(tickEnIn),
    .strobe(strobe),
    .dpStatus(dpStatus),
    .fastOut(clk8kOut),
    .slowOut(clk2kOut)
  );

  // R6: a clear never happens without enable and lock
  p_clear_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!syncEnIn || !lockedIn) |=> !(clk8kOut && clk2kOut && $past(!clk8kOut) && !$past(tickEnIn)));
endmodule

// File: tb/test_lowfreq_divsync.sv
module test_lowfreq_divsync;
  localparam int N = 6;
  localparam int SD = 4;
  localparam int P = N * SD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEnIn = 1'b0;
  logic syncRefIn = 1'b0;
  logic lockedIn = 1'b0;
  logic syncEnIn = 1'b0;
  logic clk8kOut, clk2kOut, alignDoneOut;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string curTag = "R2";
  int tickMode = 0;
  int cycleNo = 0;

  // bench model state
  int p = 0;
  bit alignM = 0;
  bit [2:0] sh = 3'b000;

  always #2 clk = ~clk;

  lowfreq_divsync #(.TICKS_PER_FAST(N), .SLOW_DIV(SD)) i_lowfreq_divsync (
    .clk(clk), .rstN(rstN), .tickEnIn(tickEnIn), .syncRefIn(syncRefIn),
    .lockedIn(lockedIn), .syncEnIn(syncEnIn), .clk8kOut(clk8kOut),
    .clk2kOut(clk2kOut), .alignDoneOut(alignDoneOut));

  task automatic chk(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) cycle %0d pos %0d: actual=%0b expected=%0b",
               req, curTag, cycleNo, p, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, check at next negedge
  task automatic step(bit refV);
    bit tk, rise, doClr;
    case (tickMode)
      0: tk = 1'b1;
      1: tk = cycleNo[0];
      default: tk = ($urandom % 10) < 7;
    endcase
    tickEnIn = tk;
    syncRefIn = refV;
    @(posedge clk);
    rise = sh[1] & ~sh[2];
    sh = {sh[1:0], refV};
    doClr = rise & syncEnIn & lockedIn & ~(alignM & (p == P - 1 || p == 0));
    if (!lockedIn) alignM = 0;
    else if (doClr) alignM = 1;
    if (doClr) p = 0;
    else if (tk) p = (p + 1) % P;
    cycleNo++;
    @(negedge clk);
    chk("R2", clk8kOut, (p % N) < N / 2);
    chk("R3", clk2kOut, p < P / 2);
    chk("R7", alignDoneOut, alignM);
  endtask

  task automatic pulse(int hi, int lo);
    for (int i = 0; i < hi; i++) step(1'b1);
    for (int i = 0; i < lo; i++) step(1'b0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    curTag = "R1";
    chk("R1", clk8kOut, 1'b1);
    chk("R1", clk2kOut, 1'b1);
    chk("R1", alignDoneOut, 1'b0);
    rstN = 1'b1;
    chk("R1", clk8kOut, 1'b1);

    // free run under each tick pattern, no sync (R2, R3, R4)
    for (int m = 0; m < 3; m++) begin
      tickMode = m;
      curTag = "R4";
      for (int i = 0; i < 2 * P; i++) step(1'b0);
    end

    // gating: edges with enable or lock low must not clear (R6)
    tickMode = 0;
    curTag = "R6";
    lockedIn = 1'b1; syncEnIn = 1'b0;
    pulse(4, P + 5);
    lockedIn = 1'b0; syncEnIn = 1'b1;
    pulse(4, P + 7);

    // first alignment (R5, R7)
    curTag = "R5";
    lockedIn = 1'b1; syncEnIn = 1'b1;
    pulse(4, 2 * P);

    // sweep edge position across the whole period, three tick patterns (R5, R8)
    for (int m = 0; m < 3; m++) begin
      tickMode = m;
      curTag = "R8";
      for (int d = 0; d < P; d++) pulse(3, P + d);
    end

    // lose lock: flag drops, then re-align from a boundary position (R7)
    curTag = "R7";
    tickMode = 2;
    lockedIn = 1'b0;
    pulse(3, P);
    lockedIn = 1'b1;
    for (int d = 0; d < P; d++) pulse(3, P + d);

    done = 1;
    summary();
  end
endmodule